// File: doc/BRIEF.md
# Password-Gated Register File

This block is the register space that sits behind a serial slave front end. It holds a stored bus address byte, a configuration byte with two high-impedance enable bits, two 8-bit setting values, a 16-bit stored password, a 16-bit volatile password entry and a small user storage area. The front end presents one read or write request per cycle. The block decodes the address, returns read data one cycle later, and decides whether each write may change state.

Write protection is based on one comparison. Writes to protected locations go through only while the volatile entry equals the stored password. The entry itself can always be written, but it can never be read back. The entry and the stored password both come up as all ones, so a freshly reset image is unlocked.

Each accepted write is also reported on a one-cycle strobe that carries its address and data. A separate commit block uses this strobe to copy the image into nonvolatile storage. The two setting values and the two high-impedance enables are driven straight from the register image.

Top module: `pwreg_file`

## Requirements
- R1: After reset the image reads as follows. 00h reads A0h, 01h reads 00h, 02h and 03h read 7Fh, 06h and 07h read FFh, and every byte in 10h–1Fh reads FFh. `setting0_o` and `setting1_o` are 7Fh, both high-impedance outputs are 0, `slave_addr_o` is A0h and `unlocked_o` is 1.
- R2: A read request sets `rd_valid_o` for exactly the next cycle. `rd_data_o` then holds the contents the location had when the request was made. A write request never sets `rd_valid_o`.
- R3: Reads of the entry bytes (04h is the high byte, 05h the low byte) return FFh whatever was written to them. Reads of 08h–0Fh and of 20h–FFh also return FFh.
- R4: While `unlocked_o` is 0, writes to any address other than 04h and 05h are discarded: no strobe is raised and no stored value or output changes. Reads still return the stored contents, including 06h (password high byte) and 07h (password low byte).
- R5: Writes to 04h and 05h are always accepted. `unlocked_o` is 1 exactly when the entry equals the stored password.
- R6: While unlocked, writes to 00h–03h, 06h, 07h and 10h–1Fh are accepted, and this includes the stored password. The comparison always uses the current contents, so a change to the password applies from the very next request.
- R7: Configuration bit 0 drives `hiz0_o` and bit 1 drives `hiz1_o`. Clearing a bit releases the output. Bits 7:2 are not stored and read as 0.
- R8: `setting0_o` follows register 02h and `setting1_o` follows register 03h. Both change on the edge that accepts the write.
- R9: In the cycle after an accepted write, `wr_acc_o` is 1 for one cycle and `wr_addr_o`/`wr_data_o` carry the request. Writes to 08h–0Fh and 20h–FFh are never accepted.
- R10: The user bytes at 10h–1Fh are independent of each other. Writing one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Read data |
| wr_acc_o | output | 1 | Accepted-write strobe |
| wr_addr_o | output | 8 | Address of accepted write |
| wr_data_o | output | 8 | Data of accepted write |
| slave_addr_o | output | 8 | Stored bus address byte |
| setting0_o | output | 8 | Setting value 0 |
| setting1_o | output | 8 | Setting value 1 |
| hiz0_o | output | 1 | High-impedance enable for output 0 |
| hiz1_o | output | 1 | High-impedance enable for output 1 |
| unlocked_o | output | 1 | Entry matches stored password |

## Verification
The bench changes the password one byte at a time. After the high byte is written, the device must already be locked, so the write of the low byte has to be refused. A design that compares against a latched copy of the password would accept that write instead. The bench then unlocks again by writing each half of the entry in turn. It confirms that reads of the entry return FFh, and a design that returned the stored entry would leak the secret through those reads. While locked, the bench checks that protected writes leave both the outputs and the read data unchanged and raise no strobe. It also writes the unimplemented holes, where a design with loose decoding would alias the write onto real storage. Finally a mid-run reset must restore the unlocked defaults.

// File: rtl/pwreg_pkg.sv
package pwreg_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int PW_W   = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] A_SLAVE = 'h00;
    localparam logic [ADDR_W-1:0] A_CFG   = 'h01;
    localparam logic [ADDR_W-1:0] A_SET0  = 'h02;
    localparam logic [ADDR_W-1:0] A_SET1  = 'h03;
    localparam logic [ADDR_W-1:0] A_ENT_H = 'h04;
    localparam logic [ADDR_W-1:0] A_ENT_L = 'h05;
    localparam logic [ADDR_W-1:0] A_PWS_H = 'h06;
    localparam logic [ADDR_W-1:0] A_PWS_L = 'h07;

    localparam logic [DATA_W-1:0] RST_SLAVE = 'hA0;
    localparam logic [DATA_W-1:0] RST_SET   = 'h7F;
    localparam logic [DATA_W-1:0] RST_USER  = '1;
    localparam logic [PW_W-1:0]   RST_PW    = '1;
    localparam logic [DATA_W-1:0] HOLE_VAL  = '1;

    typedef enum logic [3:0] {
        RG_SLAVE,
        RG_CFG,
        RG_SET0,
        RG_SET1,
        RG_ENT_H,
        RG_ENT_L,
        RG_PWS_H,
        RG_PWS_L,
        RG_USER,
        RG_NONE
    } region_e;
endpackage

// File: rtl/pwreg_decode.sv
module pwreg_decode
    import pwreg_pkg::*;
#(
    parameter int USER_BASE  = 16,
    parameter int USER_DEPTH = 16,
    localparam int UIDX_W    = $clog2(USER_DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [UIDX_W-1:0] uidx
);
    localparam logic [ADDR_W-1:0] U_LO = ADDR_W'(USER_BASE);
    localparam logic [ADDR_W-1:0] U_HI = ADDR_W'(USER_BASE + USER_DEPTH - 1);

    always_comb begin
        uidx = addr[UIDX_W-1:0];
        if (addr >= U_LO && addr <= U_HI) begin
            region = RG_USER;
        end else begin
            unique case (addr)
                A_SLAVE: region = RG_SLAVE;
                A_CFG:   region = RG_CFG;
                A_SET0:  region = RG_SET0;
                A_SET1:  region = RG_SET1;
                A_ENT_H: region = RG_ENT_H;
                A_ENT_L: region = RG_ENT_L;
                A_PWS_H: region = RG_PWS_H;
                A_PWS_L: region = RG_PWS_L;
                default: region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pwreg_guard.sv
module pwreg_guard
    import pwreg_pkg::*;
(
    input  logic [PW_W-1:0] entry,
    input  logic [PW_W-1:0] secret,
    input  region_e         region,
    output logic            match,
    output logic            allow
);
    always_comb begin
        match = (entry == secret);
        unique case (region)
            RG_ENT_H, RG_ENT_L:                 allow = 1'b1;
            RG_NONE:                            allow = 1'b0;
            RG_SLAVE, RG_CFG, RG_SET0, RG_SET1,
            RG_PWS_H, RG_PWS_L, RG_USER:        allow = match;
            default:                            allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwreg_user_mem.sv
module pwreg_user_mem
    import pwreg_pkg::*;
#(
    parameter int DEPTH      = 16,
    localparam int IDX_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_comb begin
            mem_d[g] = mem_q[g];
            if (we && idx == IDX_W'(g)) begin
                mem_d[g] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= RST_USER;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/pwreg_file.sv
module pwreg_file
    import pwreg_pkg::*;
#(
    parameter int USER_BASE  = 16,
    parameter int USER_DEPTH = 16,
    localparam int UIDX_W    = $clog2(USER_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              wr_acc_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [DATA_W-1:0] slave_addr_o,
    output logic [DATA_W-1:0] setting0_o,
    output logic [DATA_W-1:0] setting1_o,
    output logic              hiz0_o,
    output logic              hiz1_o,
    output logic              unlocked_o
);
    typedef struct packed {
        logic [DATA_W-1:0] slave;
        logic [1:0]        hiz;
        logic [DATA_W-1:0] set0;
        logic [DATA_W-1:0] set1;
        logic [PW_W-1:0]   secret;
        logic [PW_W-1:0]   entry;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
        logic              acc;
        logic [ADDR_W-1:0] acc_addr;
        logic [DATA_W-1:0] acc_data;
    } state_t;

    localparam state_t RST_STATE = '{
        slave:    RST_SLAVE,
        hiz:      2'b00,
        set0:     RST_SET,
        set1:     RST_SET,
        secret:   RST_PW,
        entry:    RST_PW,
        rd_valid: 1'b0,
        rd_data:  '0,
        acc:      1'b0,
        acc_addr: '0,
        acc_data: '0
    };

    state_t            st_d, st_q;
    region_e           region;
    logic [UIDX_W-1:0] uidx;
    logic              match;
    logic              allow;
    logic              user_we;
    logic [DATA_W-1:0] user_rdata;
    logic [DATA_W-1:0] rd_byte;
    logic              wr_ok;

    pwreg_decode #(
        .USER_BASE  (USER_BASE),
        .USER_DEPTH (USER_DEPTH)
    ) decode_i (
        .addr   (req_addr),
        .region (region),
        .uidx   (uidx)
    );

    pwreg_guard guard_i (
        .entry  (st_q.entry),
        .secret (st_q.secret),
        .region (region),
        .match  (match),
        .allow  (allow)
    );

    assign wr_ok   = req_valid && req_write && allow;
    assign user_we = wr_ok && (region == RG_USER);

    pwreg_user_mem #(
        .DEPTH (USER_DEPTH)
    ) user_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (user_we),
        .idx   (uidx),
        .wdata (req_wdata),
        .rdata (user_rdata)
    );

    always_comb begin
        unique case (region)
            RG_SLAVE: rd_byte = st_q.slave;
            RG_CFG:   rd_byte = {{(DATA_W-2){1'b0}}, st_q.hiz};
            RG_SET0:  rd_byte = st_q.set0;
            RG_SET1:  rd_byte = st_q.set1;
            RG_PWS_H: rd_byte = st_q.secret[PW_W-1:DATA_W];
            RG_PWS_L: rd_byte = st_q.secret[DATA_W-1:0];
            RG_USER:  rd_byte = user_rdata;
            default:  rd_byte = HOLE_VAL;
        endcase
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.acc      = 1'b0;
        if (req_valid && !req_write) begin
            st_d.rd_valid = 1'b1;
            st_d.rd_data  = rd_byte;
        end
        if (wr_ok) begin
            st_d.acc      = 1'b1;
            st_d.acc_addr = req_addr;
            st_d.acc_data = req_wdata;
            unique case (region)
                RG_SLAVE: st_d.slave                      = req_wdata;
                RG_CFG:   st_d.hiz                        = req_wdata[1:0];
                RG_SET0:  st_d.set0                       = req_wdata;
                RG_SET1:  st_d.set1                       = req_wdata;
                RG_ENT_H: st_d.entry[PW_W-1:DATA_W]       = req_wdata;
                RG_ENT_L: st_d.entry[DATA_W-1:0]          = req_wdata;
                RG_PWS_H: st_d.secret[PW_W-1:DATA_W]      = req_wdata;
                RG_PWS_L: st_d.secret[DATA_W-1:0]         = req_wdata;
                default:  st_d.acc_data                   = req_wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid_o   = st_q.rd_valid;
    assign rd_data_o    = st_q.rd_data;
    assign wr_acc_o     = st_q.acc;
    assign wr_addr_o    = st_q.acc_addr;
    assign wr_data_o    = st_q.acc_data;
    assign slave_addr_o = st_q.slave;
    assign setting0_o   = st_q.set0;
    assign setting1_o   = st_q.set1;
    assign hiz0_o       = st_q.hiz[0];
    assign hiz1_o       = st_q.hiz[1];
    assign unlocked_o   = match;
endmodule

// File: rtl/pwreg_file_chk.sv
module pwreg_file_chk
    import pwreg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rd_valid_o,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              wr_acc_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [DATA_W-1:0] wr_data_o,
    input logic [DATA_W-1:0] setting0_o,
    input logic [DATA_W-1:0] setting1_o,
    input logic              hiz0_o,
    input logic              hiz1_o,
    input logic              unlocked_o
);
    logic is_entry;
    logic is_hole;
    assign is_entry = (req_addr == A_ENT_H) || (req_addr == A_ENT_L);
    assign is_hole  = (req_addr >= ADDR_W'(8) && req_addr <= ADDR_W'(15)) ||
                      (req_addr >= ADDR_W'(32));

    p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid_o);

    p_no_rd_on_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rd_valid_o);

    p_entry_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && is_entry) |=> (rd_data_o == 8'hFF));

    p_locked_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !unlocked_o && !is_entry) |=> !wr_acc_o);

    p_hold_set0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc_o && wr_addr_o == A_SET0) |-> $stable(setting0_o));

    p_hold_set1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc_o && wr_addr_o == A_SET1) |-> $stable(setting1_o));

    p_entry_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && is_entry) |=> wr_acc_o);

    p_hiz_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc_o && wr_addr_o == A_CFG) |->
            (hiz0_o == wr_data_o[0] && hiz1_o == wr_data_o[1]));

    p_set0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc_o && wr_addr_o == A_SET0) |-> (setting0_o == wr_data_o));

    p_set1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc_o && wr_addr_o == A_SET1) |-> (setting1_o == wr_data_o));

    p_hole_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && is_hole) |=> !wr_acc_o);
endmodule

bind pwreg_file pwreg_file_chk chk_i (.*);

// File: tb/pwreg_file_tb.sv
module pwreg_file_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       rd_valid_o, wr_acc_o, hiz0_o, hiz1_o, unlocked_o;
    logic [7:0] rd_data_o, wr_addr_o, wr_data_o, slave_addr_o, setting0_o, setting1_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    pwreg_file dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid_o(rd_valid_o),
        .rd_data_o(rd_data_o), .wr_acc_o(wr_acc_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .slave_addr_o(slave_addr_o), .setting0_o(setting0_o),
        .setting1_o(setting1_o), .hiz0_o(hiz0_o), .hiz1_o(hiz1_o), .unlocked_o(unlocked_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid_o === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected rd_valid", 1, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, rd_data_o, e);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit acc, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, wr_acc_o, acc);
        if (acc) begin
            chk({tag, " addr"}, wr_addr_o, a);
            chk({tag, " data"}, wr_data_o, d);
        end
        chk("R2 no rd_valid on write", rd_valid_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs
        chk("R1 setting0", setting0_o, 8'h7F);
        chk("R1 setting1", setting1_o, 8'h7F);
        chk("R1 hiz", {hiz1_o, hiz0_o}, 0);
        chk("R1 slave", slave_addr_o, 8'hA0);
        chk("R1 unlocked", unlocked_o, 1);
        chk("R1 wr_acc idle", wr_acc_o, 0);
        rd(8'h00, 8'hA0, "R1 read 00");
        rd(8'h01, 8'h00, "R1 read 01");
        rd(8'h02, 8'h7F, "R1 read 02");
        rd(8'h03, 8'h7F, "R1 read 03");
        rd(8'h06, 8'hFF, "R1 read 06");
        rd(8'h07, 8'hFF, "R1 read 07");
        for (int i = 16; i < 32; i++) rd(8'(i), 8'hFF, "R1 user default");
        // R3 holes and entry
        rd(8'h04, 8'hFF, "R3 entry hi");
        rd(8'h05, 8'hFF, "R3 entry lo");
        rd(8'h08, 8'hFF, "R3 hole 08");
        rd(8'h0F, 8'hFF, "R3 hole 0F");
        rd(8'h20, 8'hFF, "R3 hole 20");
        rd(8'hFF, 8'hFF, "R3 hole FF");
        // R8 setting writes
        wr(8'h02, 8'h33, 1, "R9 accept set0");
        chk("R8 setting0", setting0_o, 8'h33);
        rd(8'h02, 8'h33, "R8 read 02");
        // R7 config
        wr(8'h01, 8'h01, 1, "R7 cfg 01");
        chk("R7 hiz after 01", {hiz1_o, hiz0_o}, 2'b01);
        wr(8'h01, 8'hFE, 1, "R7 cfg FE");
        chk("R7 hiz after FE", {hiz1_o, hiz0_o}, 2'b10);
        rd(8'h01, 8'h02, "R7 upper bits read 0");
        wr(8'h01, 8'h00, 1, "R7 cfg 00");
        chk("R7 hiz released", {hiz1_o, hiz0_o}, 2'b00);
        // R10 user bytes
        wr(8'h10, 8'h5A, 1, "R10 user 10");
        wr(8'h1F, 8'hA5, 1, "R10 user 1F");
        rd(8'h10, 8'h5A, "R10 read 10");
        rd(8'h1F, 8'hA5, "R10 read 1F");
        rd(8'h11, 8'hFF, "R10 neighbour 11");
        // R9 holes discarded
        wr(8'h08, 8'h00, 0, "R9 hole 08 write");
        wr(8'h40, 8'h00, 0, "R9 hole 40 write");
        rd(8'h08, 8'hFF, "R9 hole 08 after write");
        rd(8'h00, 8'hA0, "R9 no alias onto 00");
        // R6 password change applies at once
        wr(8'h06, 8'h12, 1, "R6 pw hi");
        chk("R6 locked after pw hi", unlocked_o, 0);
        wr(8'h07, 8'h34, 0, "R6 pw lo refused");
        rd(8'h07, 8'hFF, "R4 pw lo unchanged");
        // R4 locked
        wr(8'h02, 8'h55, 0, "R4 set0 refused");
        chk("R4 setting0 held", setting0_o, 8'h33);
        rd(8'h02, 8'h33, "R4 read 02");
        wr(8'h10, 8'h77, 0, "R4 user refused");
        rd(8'h10, 8'h5A, "R4 user held");
        // R5 unlock via entry
        wr(8'h04, 8'h12, 1, "R5 entry hi");
        chk("R5 unlocked 12FF", unlocked_o, 1);
        wr(8'h07, 8'h34, 1, "R6 pw lo accepted");
        chk("R6 locked 1234", unlocked_o, 0);
        wr(8'h05, 8'h34, 1, "R5 entry lo");
        chk("R5 unlocked 1234", unlocked_o, 1);
        wr(8'h03, 8'hC8, 1, "R6 set1 accepted");
        chk("R8 setting1", setting1_o, 8'hC8);
        wr(8'h00, 8'hB4, 1, "R6 slave accepted");
        chk("R6 slave out", slave_addr_o, 8'hB4);
        wr(8'h04, 8'h00, 1, "R5 entry relock");
        chk("R5 locked", unlocked_o, 0);
        rd(8'h06, 8'h12, "R4 read pw hi");
        rd(8'h07, 8'h34, "R4 read pw lo");
        rd(8'h04, 8'hFF, "R3 entry hidden");
        wr(8'h01, 8'h03, 0, "R4 cfg refused");
        chk("R4 hiz held", {hiz1_o, hiz0_o}, 2'b00);
        // reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 unlocked after reset", unlocked_o, 1);
        chk("R1 setting0 after reset", setting0_o, 8'h7F);
        chk("R1 slave after reset", slave_addr_o, 8'hA0);
        rd(8'h06, 8'hFF, "R1 pw after reset");
        repeat (3) @(negedge clk);
        chk("R2 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule